// File: doc/BRIEF.md
# Approximate 4-2 Compressor Slice

This block is one column slice of a partial-product reduction tree. It takes four operand bits of equal weight and a lateral carry from the column to its right. It returns a sum bit of the same weight, a carry bit of double weight, and a lateral carry-out of double weight that goes to the column to its left. A static two-bit mode input picks the behaviour. The exact mode is built from two chained full adders. The two approximate modes give up a known amount of accuracy so that the logic gets shallower.

In the first approximate mode the carry output is simply the lateral carry-in, and the sum is held at zero whenever the carry-in is set. In the second approximate mode the lateral chain is cut: the carry-in has no effect and the carry-out is held at zero. A register stage presents all three outputs one clock after the inputs, so the slice can be timed on its own.

Top module: `apx_comp42`

## Requirements
- R1: In mode 2'b00 the registered outputs satisfy popcount(opIn) + cinIn = sumQ + 2*(carryQ + coutQ) for all 32 input patterns.
- R2: In mode 2'b00, coutQ equals the majority of opIn[0], opIn[1] and opIn[2], whatever the value of cinIn.
- R3: In mode 2'b01, carryQ equals cinIn.
- R4: In mode 2'b01, sumQ is 0 whenever cinIn is 1.
- R5: In mode 2'b01, coutQ = (opIn[0]&opIn[1]) | (opIn[2]&opIn[3]) | (opIn[0]&opIn[2]). With cinIn 0, sumQ is 0 when opIn has zero set bits. It is the inverse of coutQ when opIn has exactly two set bits, and 1 otherwise.
- R6: Mode 2'b01 gives a wrong arithmetic value on exactly 12 of the 32 patterns, and every wrong value is off by exactly 1.
- R7: In mode 2'b10, carryQ follows the R5 coutQ expression and sumQ follows the R5 sum rule for cinIn 0. cinIn has no effect on any output.
- R8: In mode 2'b10, coutQ is always 0.
- R9: Mode 2'b11 behaves exactly like mode 2'b00.
- R10: Each output reflects the inputs applied before the previous rising clock edge, so the latency is one cycle.
- R11: While rst is high at a rising edge, all three outputs are cleared to 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| modeIn | input | 2 | Behaviour select: 00 exact, 01 approx 1, 10 approx 2, 11 exact |
| opIn | input | 4 | The four column operand bits, opIn[0] first |
| cinIn | input | 1 | Lateral carry from the lower column |
| sumQ | output | 1 | Registered sum bit, weight 1 |
| carryQ | output | 1 | Registered carry bit, weight 2 |
| coutQ | output | 1 | Registered lateral carry-out, weight 2 |

## Verification
The hardest case to reach is a pair of patterns in the second approximate mode that differ only in cinIn. The outputs must be identical, and this shows only when the two appear in adjacent cycles. The sweep therefore walks cinIn as the lowest bit of the pattern index, so each operand value is applied with cinIn 0 and then with cinIn 1 back to back. Erroneous patterns in the first approximate mode are counted over the full sweep, and the count must come to exactly twelve.

// File: rtl/cmp42_pkg.sv
package cmp42_pkg;
  localparam int ModeW = 2;
  localparam int OpW   = 4;

  typedef enum logic [ModeW-1:0] {
    MODE_EXACT = 2'b00,
    MODE_APX1  = 2'b01,
    MODE_APX2  = 2'b10,
    MODE_RSVD  = 2'b11
  } cmpMode_e;

  typedef struct packed {
    logic useExact;
    logic useApx1;
    logic useApx2;
  } cmpSel_t;
endpackage

// File: rtl/cmp42_fa.sv
module cmp42_fa (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic s,
  output logic co
);
  logic axb;
  assign axb = a ^ b;
  assign s   = axb ^ c;
  assign co  = axb ? c : a;
endmodule

// File: rtl/cmp42_ctrl.sv
module cmp42_ctrl
  import cmp42_pkg::*;
(
  input  logic [ModeW-1:0] modeIn,
  output cmpSel_t          sel
);
  always_comb begin
    sel = '0;
    unique case (cmpMode_e'(modeIn))
      MODE_APX1: sel.useApx1 = 1'b1;
      MODE_APX2: sel.useApx2 = 1'b1;
      default:   sel.useExact = 1'b1;  // exact and reserved
    endcase
  end
endmodule

// File: rtl/cmp42_dp.sv
module cmp42_dp
  import cmp42_pkg::*;
(
  input  logic [OpW-1:0] opIn,
  input  logic           cinIn,
  input  cmpSel_t        sel,
  output logic           sumD,
  output logic           carryD,
  output logic           coutD
);
  localparam int CntW = $clog2(OpW + 2) + 1;

  // exact path: two chained full adders
  logic faSum1, exSum, exCarry, exCout;

  cmp42_fa u_fa1 (.a(opIn[0]), .b(opIn[1]), .c(opIn[2]), .s(faSum1), .co(exCout));
  cmp42_fa u_fa2 (.a(faSum1),  .b(opIn[3]), .c(cinIn),   .s(exSum),  .co(exCarry));

  // approximate terms
  logic pairHi, anyOne, allOne, oddOnes, apxSum0;
  assign pairHi  = (opIn[0] & opIn[1]) | (opIn[2] & opIn[3]) | (opIn[0] & opIn[2]);
  assign anyOne  = |opIn;
  assign allOne  = &opIn;
  assign oddOnes = ^opIn;
  // sum with no carry-in: zero for no ones, ~pairHi for two ones, else 1
  assign apxSum0 = anyOne & ~(~oddOnes & ~allOne & pairHi);

  always_comb begin
    sumD   = exSum;
    carryD = exCarry;
    coutD  = exCout;
    if (sel.useApx1) begin
      sumD   = apxSum0 & ~cinIn;
      carryD = cinIn;
      coutD  = pairHi;
    end else if (sel.useApx2) begin
      sumD   = apxSum0;
      carryD = pairHi;
      coutD  = 1'b0;
    end
  end

  // local checks
  logic [CntW-1:0] exactVal, outVal;
  assign exactVal = CntW'($countones(opIn)) + CntW'(cinIn);
  assign outVal   = CntW'(sumD) + CntW'(2 * (int'(carryD) + int'(coutD)));

  always_comb begin
    if (sel.useExact)
      AST_EXACT_VALUE: assert (outVal == exactVal);  // R1
    if (sel.useApx1)
      AST_APX1_CARRY: assert (carryD == cinIn);  // R3
    if (sel.useApx1)
      AST_APX1_DIST: assert ((outVal == exactVal) || (outVal == exactVal + 1'b1)
                             || (outVal + 1'b1 == exactVal));  // R6
    if (sel.useApx2)
      AST_APX2_COUT: assert (coutD == 1'b0);  // R8
  end
endmodule

// File: rtl/apx_comp42.sv
module apx_comp42
  import cmp42_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [ModeW-1:0] modeIn,
  input  logic [OpW-1:0]   opIn,
  input  logic             cinIn,
  output logic             sumQ,
  output logic             carryQ,
  output logic             coutQ
);
  cmpSel_t sel;
  logic    sumD, carryD, coutD;

  cmp42_ctrl u_ctrl (.modeIn(modeIn), .sel(sel));

  cmp42_dp u_dp (
    .opIn(opIn), .cinIn(cinIn), .sel(sel),
    .sumD(sumD), .carryD(carryD), .coutD(coutD)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sumQ   <= 1'b0;
      carryQ <= 1'b0;
      coutQ  <= 1'b0;
    end else begin
      sumQ   <= sumD;
      carryQ <= carryD;
      coutQ  <= coutD;
    end
  end

  AST_APX2_COUT_Q: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(modeIn) == MODE_APX2) |-> !coutQ);  // R8

  AST_APX1_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(modeIn) == MODE_APX1) |-> carryQ == $past(cinIn));  // R10

  AST_EXACT_COUT_Q: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(modeIn) == MODE_EXACT) |->
      coutQ == (($past(opIn[0]) & $past(opIn[1])) | ($past(opIn[0]) & $past(opIn[2]))
                | ($past(opIn[1]) & $past(opIn[2]))));  // R2
endmodule

// File: tb/apx_comp42_test.sv
module apx_comp42_test;
  localparam int ClkPeriod = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] modeIn = 2'b00;
  logic [3:0] opIn = 4'h0;
  logic       cinIn = 1'b0;
  logic       sumQ, carryQ, coutQ;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int errCnt  [4];
  int maxDist [4];

  typedef struct {
    logic [1:0] mode;
    logic [3:0] op;
    logic       cin;
    logic       eSum, eCarry, eCout;
  } item_t;

  item_t sbq[$];

  apx_comp42 uut (
    .clk(clk), .rst(rst), .modeIn(modeIn), .opIn(opIn), .cinIn(cinIn),
    .sumQ(sumQ), .carryQ(carryQ), .coutQ(coutQ)
  );

  always #(ClkPeriod/2) clk = ~clk;

  function automatic int pop4(input logic [3:0] v);
    int n = 0;
    for (int i = 0; i < 4; i++) n += int'(v[i]);
    return n;
  endfunction

  // expectations taken from the requirement text
  function automatic item_t model(input logic [1:0] m, input logic [3:0] x, input logic c);
    item_t it;
    int n4, tot;
    logic ph, s0;
    it.mode = m; it.op = x; it.cin = c;
    n4 = pop4(x);
    ph = (x[0] & x[1]) | (x[2] & x[3]) | (x[0] & x[2]);
    s0 = (n4 == 0) ? 1'b0 : (n4 == 2) ? ~ph : 1'b1;
    case (m)
      2'b01: begin it.eSum = c ? 1'b0 : s0; it.eCarry = c; it.eCout = ph; end
      2'b10: begin it.eSum = s0; it.eCarry = ph; it.eCout = 1'b0; end
      default: begin
        tot = n4 + int'(c);
        it.eSum  = tot[0];
        it.eCout = (x[0] & x[1]) | (x[0] & x[2]) | (x[1] & x[2]);
        it.eCarry = 1'((tot >> 1) - int'(it.eCout));
      end
    endcase
    return it;
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drivePat(input logic [1:0] m, input logic [3:0] x, input logic c);
    @(negedge clk);
    modeIn = m; opIn = x; cinIn = c;
    sbq.push_back(model(m, x, c));
  endtask

  function automatic string reqOf(input logic [1:0] m);
    case (m)
      2'b01: return "R3/R4/R5";
      2'b10: return "R7/R8";
      2'b11: return "R9";
      default: return "R1/R2";
    endcase
  endfunction

  // monitor: one item per cycle, sampled a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(ClkPeriod/4);
      if (!rst && sbq.size() > 0) begin
        item_t it;
        int act, ex, d;
        it = sbq.pop_front();
        check(reqOf(it.mode), int'({sumQ, carryQ, coutQ}),
              int'({it.eSum, it.eCarry, it.eCout}),
              $sformatf("R10 mode %0d op %b cin %b {sum,carry,cout}", it.mode, it.op, it.cin));
        act = int'(sumQ) + 2 * (int'(carryQ) + int'(coutQ));
        ex  = pop4(it.op) + int'(it.cin);
        d   = (act > ex) ? act - ex : ex - act;
        if (d != 0) errCnt[it.mode]++;
        if (d > maxDist[it.mode]) maxDist[it.mode] = d;
      end
    end
  end

  initial begin
    logic [2:0] v2Prev;
    for (int k = 0; k < 4; k++) begin errCnt[k] = 0; maxDist[k] = 0; end
    // reset with busy inputs: R11
    modeIn = 2'b00; opIn = 4'hF; cinIn = 1'b1; rst = 1'b1;
    @(posedge clk); #(ClkPeriod/4);
    check("R11", int'({sumQ, carryQ, coutQ}), 0, "outputs in reset");
    @(posedge clk); #(ClkPeriod/4);
    check("R11", int'({sumQ, carryQ, coutQ}), 0, "outputs held in reset");
    @(negedge clk); rst = 1'b0;

    // full sweeps, cin as lowest index bit
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 32; p++)
        drivePat(2'(m), p[4:1], p[0]);
    repeat (3) @(negedge clk);

    // R7: cin pairs in mode 2'b10 give equal outputs in back-to-back cycles
    for (int x = 0; x < 16; x++) begin
      drivePat(2'b10, 4'(x), 1'b0);
      @(posedge clk); #(ClkPeriod/4);
      v2Prev = {sumQ, carryQ, coutQ};
      drivePat(2'b10, 4'(x), 1'b1);
      @(posedge clk); #(ClkPeriod/4);
      check("R7", int'({sumQ, carryQ, coutQ}), int'(v2Prev), $sformatf("cin ignored op %b", x));
    end
    repeat (3) @(negedge clk);

    // mid-run reset clears outputs: R11
    @(negedge clk); modeIn = 2'b00; opIn = 4'hF; cinIn = 1'b1;
    @(posedge clk); #(ClkPeriod/4);
    check("R1", int'({sumQ, carryQ, coutQ}), 3'b111, "all ones exact");
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #(ClkPeriod/4);
    check("R11", int'({sumQ, carryQ, coutQ}), 0, "mid-run reset");
    @(negedge clk); rst = 1'b0;

    check("R1", errCnt[0], 0, "exact mode error count");
    check("R9", errCnt[3], 0, "reserved mode error count");
    check("R6", errCnt[1], 12, "approx-1 error count");
    check("R6", maxDist[1], 1, "approx-1 max error distance");
    $display("mode 00 errors %0d max %0d", errCnt[0], maxDist[0]);
    $display("mode 01 errors %0d max %0d", errCnt[1], maxDist[1]);
    $display("mode 10 errors %0d max %0d", errCnt[2], maxDist[2]);
    $display("mode 11 errors %0d max %0d", errCnt[3], maxDist[3]);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(ClkPeriod * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule